// File: doc/BRIEF.md
# Minute Pulse Generator from a Line-Frequency Tick

The block turns a slow, already squared mains-rate tick into one short pulse per minute. The tick is sampled into the system clock domain, and each high-to-low transition of the tick advances a 12-bit binary count by one. The terminal count of 3600 is detected by a partial decode. Only the count bits that are set in 3600 are ANDed together. No full equality compare is used. The same decode clears the count and fires the output pulse. With a 60 Hz tick, the output therefore carries exactly one pulse per minute.

Every decision is registered on the system clock. Transient decode states therefore never reach the pulse output, which is the hazard a rippled count would carry. The live count is also brought out, so that a consumer can watch progress within the current minute. An asynchronous active-high reset clears the count and holds the pulse low. It also suppresses edge detection, so releasing it never creates a spurious count.

Top module: `minpulse_gen`

## Requirements
- R1: While `rst_i` is high, `count_o` reads 0 and `pulse_o` reads 0. Asserting `rst_i` clears the count at once, without waiting for a clock edge.
- R2: Each high-to-low transition of `tick_i` raises `count_o` by exactly one. The new value is visible within three system-clock cycles of the transition.
- R3: A low-to-high transition of `tick_i`, or a steady tick level of any length, leaves `count_o` unchanged.
- R4: The terminal count is the AND of count bits 4, 9, 10 and 11 (bit 0 = weight 1), which first occurs at 3600. The transition that would produce it loads 0 into the count and asserts `pulse_o`, so `count_o` reads 0 whenever `pulse_o` is high.
- R5: `pulse_o` is high for exactly one system-clock cycle per terminal count.
- R6: `count_o` never holds a value of 3600 or above. It cycles through 0 to 3599.
- R7: Exactly one pulse appears for every 3600 falling tick transitions. From reset, the pulses fall on transitions 3600, 7200, and so on.
- R8: After `rst_i` is released with `tick_i` held high, no count occurs until the first falling tick transition, and that transition makes the count 1. Falling transitions seen while reset is high are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all state updates on its rising edge |
| rst_i | input | 1 | Asynchronous active-high reset |
| tick_i | input | 1 | Squared line-frequency tick, asynchronous to `clk_i` |
| pulse_o | output | 1 | One-cycle pulse at each terminal count |
| count_o | output | 12 | Live count of falling tick transitions since the last pulse |

## Verification
A wrong count step shows at `count_o` within three system-clock cycles of the tick transition that caused it. It then stays wrong for every later comparison against the falling-edge total kept by the bench. A wrong decode, or a missing clear, shows up in two ways. Either `count_o` reaches 3600, or the pulse lands away from a multiple of 3600 transitions, in which case the error is visible before the next transition. A synchronizer that double-counts or drops edges shifts the count immediately. It also shifts both pulse positions in the 7200-transition run.

// File: rtl/minpulse_pkg.sv
package minpulse_pkg;

    // Default geometry of the minute divider.
    localparam int unsigned MP_CNT_W   = 12;
    localparam int unsigned MP_TERM    = 3600;
    localparam int unsigned MP_SYNC_N  = 2;

endpackage

// File: rtl/minpulse_tick_edge.sv
module minpulse_tick_edge #(
    parameter int unsigned SYNC_N = minpulse_pkg::MP_SYNC_N
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    output logic fall_o
);

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = tick_i;
        for (int i = 1; i < SYNC_N; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.last = st_q.sync[SYNC_N-1];
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A fall is the synchronized level low while the prior sample was high.
    assign fall_o = st_q.last & ~st_q.sync[SYNC_N-1];

    AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_o |=> !fall_o); // R3

endmodule

// File: rtl/minpulse_term_decode.sv
module minpulse_term_decode #(
    parameter int unsigned CNT_W = minpulse_pkg::MP_CNT_W,
    parameter int unsigned TERM  = minpulse_pkg::MP_TERM
) (
    input  logic [CNT_W-1:0] value_i,
    output logic             hit_o
);

    localparam logic [CNT_W-1:0] TERM_MASK = CNT_W'(TERM);

    logic [CNT_W-1:0] lane;

    // Bits that are clear in the terminal value do not take part in the AND.
    for (genvar g = 0; g < CNT_W; g++) begin : g_lane
        if (TERM_MASK[g]) begin : g_used
            assign lane[g] = value_i[g];
        end else begin : g_skip
            assign lane[g] = 1'b1;
        end
    end

    assign hit_o = &lane;

endmodule

// File: rtl/minpulse_counter.sv
module minpulse_counter #(
    parameter int unsigned CNT_W = minpulse_pkg::MP_CNT_W,
    parameter int unsigned TERM  = minpulse_pkg::MP_TERM
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pulse_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] inc;
    logic             term_hit;

    assign inc = st_q.cnt + CNT_W'(1);

    minpulse_term_decode #(
        .CNT_W (CNT_W),
        .TERM  (TERM)
    ) i_decode (
        .value_i (inc),
        .hit_o   (term_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (adv_i) begin
            if (term_hit) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt   = inc;
            end
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign pulse_o = st_q.pulse;

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |-> (count_o == '0 && !pulse_o)); // R1
    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (count_o != $past(count_o)) |-> (count_o == CNT_W'($past(count_o) + CNT_W'(1)) || (count_o == '0 && pulse_o))); // R2
    AST_PULSE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> (count_o == '0)); // R4
    AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o); // R5
    AST_BELOW_TERM: assert property (@(posedge clk_i) disable iff (rst_i)
        count_o < CNT_W'(TERM)); // R6

endmodule

// File: rtl/minpulse_gen.sv
module minpulse_gen #(
    parameter int unsigned CNT_W  = minpulse_pkg::MP_CNT_W,
    parameter int unsigned TERM   = minpulse_pkg::MP_TERM,
    parameter int unsigned SYNC_N = minpulse_pkg::MP_SYNC_N
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    output logic             pulse_o,
    output logic [CNT_W-1:0] count_o
);

    logic fall;

    minpulse_tick_edge #(
        .SYNC_N (SYNC_N)
    ) i_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick_i),
        .fall_o (fall)
    );

    minpulse_counter #(
        .CNT_W (CNT_W),
        .TERM  (TERM)
    ) i_counter (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .adv_i   (fall),
        .count_o (count_o),
        .pulse_o (pulse_o)
    );

    AST_PULSE_NEEDS_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> $past(fall)); // R7

endmodule

// File: tb/test_minpulse_gen.sv
module test_minpulse_gen;

    localparam int CLK_PERIOD = 10;
    localparam int TERM       = 3600;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        tick_i = 1'b1;
    logic        pulse_o;
    logic [11:0] count_o;

    int n_run  = 0;
    int n_fail = 0;
    int falls  = 0;
    int pulses = 0;
    int last_pulse_fall = 0;
    int max_cnt = 0;
    bit mon_on = 1'b0;
    bit prev_pulse = 1'b0;
    bit done = 1'b0;

    minpulse_gen i_minpulse_gen (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick_i),
        .pulse_o (pulse_o),
        .count_o (count_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_count(input int nfalls);
        return nfalls % TERM;
    endfunction

    function automatic int rand_len();
        return 4 + int'($urandom_range(0, 4));
    endfunction

    // Pulse monitor, sampling away from the active edge.
    always @(negedge clk_i) begin
        if (mon_on && !rst_i) begin
            if (int'(count_o) > max_cnt) max_cnt = int'(count_o);
            if (pulse_o) begin
                pulses++;
                chk(count_o == 12'd0, "R4 count zero with pulse", int'(count_o), 0);
                chk(!prev_pulse, "R5 pulse one cycle", int'(prev_pulse), 0);
                chk(falls % TERM == 0, "R7 pulse on multiple of 3600", falls, (falls / TERM) * TERM);
                if (pulses > 1)
                    chk(falls - last_pulse_fall == TERM, "R7 pulse spacing", falls - last_pulse_fall, TERM);
                last_pulse_fall = falls;
            end
            prev_pulse = pulse_o;
        end
    end

    task automatic do_fall(input bit check_rise);
        int lo = rand_len();
        int hi = rand_len();
        tick_i = 1'b0;
        falls++;
        repeat (lo) @(negedge clk_i);
        chk(int'(count_o) == exp_count(falls), "R2 count after fall", int'(count_o), exp_count(falls));
        tick_i = 1'b1;
        repeat (hi) @(negedge clk_i);
        if (check_rise)
            chk(int'(count_o) == exp_count(falls), "R3 rise ignored", int'(count_o), exp_count(falls));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_i);
        chk(count_o == 12'd0 && !pulse_o, "R1 reset state", int'(count_o), 0);
        rst_i = 1'b0;
        repeat (6) @(negedge clk_i);
        chk(count_o == 12'd0, "R8 no count at release", int'(count_o), 0);

        // Directed: a few counts, then asynchronous reset mid-count.
        falls = 0;
        for (int k = 0; k < 37; k++) do_fall(1'b1);
        repeat (20) @(negedge clk_i);
        chk(int'(count_o) == 37, "R3 steady level ignored", int'(count_o), 37);
        #3 rst_i = 1'b1;
        #1 chk(count_o == 12'd0 && !pulse_o, "R1 async clear", int'(count_o), 0);
        @(negedge clk_i);
        for (int k = 0; k < 3; k++) begin
            tick_i = 1'b0;
            repeat (4) @(negedge clk_i);
            tick_i = 1'b1;
            repeat (4) @(negedge clk_i);
        end
        chk(count_o == 12'd0 && !pulse_o, "R1 held in reset", int'(count_o), 0);
        rst_i = 1'b0;
        repeat (8) @(negedge clk_i);
        chk(count_o == 12'd0, "R8 no spurious count", int'(count_o), 0);
        falls = 0;
        do_fall(1'b1);
        chk(int'(count_o) == 1, "R8 first fall counts one", int'(count_o), 1);

        // Main run from a clean reset: 7200 falling transitions.
        @(negedge clk_i);
        rst_i = 1'b1;
        repeat (2) @(negedge clk_i);
        rst_i = 1'b0;
        repeat (4) @(negedge clk_i);
        falls = 0;
        pulses = 0;
        max_cnt = 0;
        prev_pulse = 1'b0;
        mon_on = 1'b1;
        for (int k = 0; k < 2 * TERM; k++) do_fall(k % 50 == 0);
        repeat (10) @(negedge clk_i);
        mon_on = 1'b0;
        chk(pulses == 2, "R7 pulse total", pulses, 2);
        chk(last_pulse_fall == 2 * TERM, "R7 last pulse position", last_pulse_fall, 2 * TERM);
        chk(count_o == 12'd0, "R4 count zero after pulse", int'(count_o), 0);
        chk(max_cnt < TERM, "R6 maximum count", max_cnt, TERM - 1);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", falls, 2 * TERM);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule